// File: doc/BRIEF.md
# Byte-Wide NOR Flash Command Interface

This block is the device-side command engine of a byte-wide parallel NOR flash. It has a 19-bit address and a small synthesizable storage array behind it. The host drives an asynchronous bus with three active-low strobes: chip enable, write enable and output enable. The block brings those strobes into its own clock domain and finds the start and end of each write cycle. It then follows the unlock and command sequences for read/reset, byte program, identification and chip erase. On each read it returns array data, identification data or polling status, chosen by its state.

Embedded program and erase are modelled as internal countdowns whose lengths are parameters. A busy flag is brought out for observation. Sector protection is not stored inside the block: it comes from a static input vector with one bit per 64 KiB sector.

The state machine has these states:

- `S_READ`: array read, the power-up state.
- `S_IDENT`: identification read.
- `S_UNLK1`: first unlock cycle seen.
- `S_UNLK2`: second unlock cycle seen, waiting for the command byte.
- `S_PGM_WAIT`: waiting for the program address and data.
- `S_PGM_RUN`: program running.
- `S_ERA_UNLK0`, `S_ERA_UNLK1`, `S_ERA_CMD`: the second unlock pair and the confirm byte of an erase.
- `S_ERA_RUN`: erase running.

The transitions are:

- The first unlock moves a resting state (`S_READ` or `S_IDENT`) to `S_UNLK1`.
- The second unlock moves `S_UNLK1` to `S_UNLK2`.
- In `S_UNLK2`, the command byte selects `S_PGM_WAIT`, `S_IDENT`, `S_READ` or `S_ERA_UNLK0`.
- The next write moves `S_PGM_WAIT` to `S_PGM_RUN`.
- The erase steps move `S_ERA_UNLK0` to `S_ERA_UNLK1`, then to `S_ERA_CMD`, then to `S_ERA_RUN`.
- Both running states return to `S_READ` when their countdown ends.
- A wrong write in any sequence state falls back to the resting state the machine came from.

Top module: `pflash_cmd_ctrl`

## Requirements
- R1: After reset the block is in array read mode with `busy` low, and every stored byte reads FFh with no command written.
- R2: `dout_en` is high only while both `ce_n` and `oe_n` are low, and `dout` is 00h whenever `dout_en` is low.
- R3: A program is entered by AAh written at address 5555h, then 55h at 2AAAh, then A0h at 5555h. Only the low 15 address bits are compared. The fourth write supplies the target. Its address is taken when the later of `ce_n`/`we_n` falls, and its data is taken when the earlier of them rises. That same rising edge starts the program, and `busy` rises.
- R4: While a program runs, every read returns the complement of the written bit 7 on `dout[7]` and zeros on `dout[6:0]`.
- R5: Programming stores the bitwise AND of the old and new bytes, so no bit ever goes from 0 to 1.
- R6: After the program countdown ends, `busy` falls, the block returns to array read mode, and the target address reads the programmed value.
- R7: In identification mode, a read with address bits 7..0 equal to 00h returns ADh and a read with 01h returns A4h. Both codes have odd parity, with bit 7 as the parity bit.
- R8: In identification mode, a read with A6=0, A1=1, A0=0 (other than at low byte 00h/01h) returns 01h if the sector selected by A18..A16 has its `sect_prot` bit set and 00h otherwise. Any other identification address returns 00h.
- R9: Identification mode lasts until the sequence AAh@5555h, 55h@2AAAh, F0h@5555h is written. A broken sequence returns to identification mode, not to array read.
- R10: A write that does not match the next expected step of a sequence abandons the sequence without changing the array.
- R11: Chip erase is the six writes AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, 10h@5555h. It runs for the erase countdown, reads 00h while running, and leaves every byte at FFh.
- R12: Writes issued while `busy` is high are ignored: they neither shorten the operation nor change what reads return during it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock used to sample the asynchronous bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip enable strobe, active low |
| we_n | input | 1 | Write enable strobe, active low |
| oe_n | input | 1 | Output enable strobe, active low |
| addr | input | 19 | Byte address |
| din | input | 8 | Write data |
| dout | output | 8 | Read data, 00h when not enabled |
| dout_en | output | 1 | High while a read is enabled on the bus |
| sect_prot | input | 8 | Static protection flag per sector, indexed by A18..A16 |
| busy | output | 1 | High while an embedded program or erase runs |

## Verification
The two functions that can land in one cycle are the end of an embedded program and a status read held open across it. In that cycle the state leaves `S_PGM_RUN` and the array takes the ANDed byte. The bench holds `oe_n` low on the program address and samples on every clock until `busy` drops. Every sample taken while busy must show the inverted bit 7 over zeros, and the first sample after busy falls must already show the full programmed byte, with no mixed value in between. A second overlap is host writes arriving during an erase countdown. Reads taken after those writes must still show 00h, and `busy` must stay high.

// File: rtl/pfc_pkg.sv
`timescale 1ns/1ps
package pfc_pkg;

    typedef enum logic [3:0] {
        S_READ,
        S_IDENT,
        S_UNLK1,
        S_UNLK2,
        S_PGM_WAIT,
        S_PGM_RUN,
        S_ERA_UNLK0,
        S_ERA_UNLK1,
        S_ERA_CMD,
        S_ERA_RUN
    } fsm_t;

    localparam int unsigned CMD_AW = 15;

    localparam logic [CMD_AW-1:0] KEY_ADDR_A = 15'h5555;
    localparam logic [CMD_AW-1:0] KEY_ADDR_B = 15'h2AAA;

    localparam logic [7:0] KEY_BYTE_A  = 8'hAA;
    localparam logic [7:0] KEY_BYTE_B  = 8'h55;
    localparam logic [7:0] OP_PROGRAM  = 8'hA0;
    localparam logic [7:0] OP_IDENT    = 8'h90;
    localparam logic [7:0] OP_RESET    = 8'hF0;
    localparam logic [7:0] OP_ERASE    = 8'h80;
    localparam logic [7:0] OP_ERA_CONF = 8'h10;

    localparam logic [7:0] MAKER_CODE = 8'hAD;
    localparam logic [7:0] PART_CODE  = 8'hA4;

endpackage

// File: rtl/pfc_bus_sync.sv
`timescale 1ns/1ps
module pfc_bus_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n,
    input  logic we_n,
    input  logic oe_n,
    output logic wr_start,
    output logic wr_end,
    output logic rd_on
);

    localparam int unsigned NSIG = 3;

    logic [NSIG-1:0] raw;
    logic [NSIG-1:0] synced;
    logic            wr_act;
    logic            wr_act_q;

    assign raw = {ce_n, we_n, oe_n};

    for (genvar i = 0; i < STAGES; i++) begin : g_stg
        logic [NSIG-1:0] q;
        if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) q <= '1;
                else        q <= raw;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) q <= '1;
                else        q <= g_stg[i-1].q;
            end
        end
    end

    assign synced = g_stg[STAGES-1].q;

    // A write cycle is the overlap of chip enable and write enable
    assign wr_act = !synced[2] && !synced[1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wr_act_q <= 1'b0;
        else        wr_act_q <= wr_act;
    end

    assign wr_start = wr_act && !wr_act_q;
    assign wr_end   = !wr_act && wr_act_q;
    assign rd_on    = !synced[2] && !synced[0];

endmodule

// File: rtl/pfc_seq.sv
`timescale 1ns/1ps
module pfc_seq
    import pfc_pkg::*;
#(
    parameter int unsigned MEM_AW      = 6,
    parameter int unsigned PGM_CYCLES  = 20,
    parameter int unsigned ERA_CYCLES  = 80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_start,
    input  logic              wr_end,
    input  logic [CMD_AW-1:0] bus_addr,
    input  logic [7:0]        bus_data,
    output fsm_t              state,
    output logic              busy,
    output logic              id_view,
    output logic              prog_fire,
    output logic [MEM_AW-1:0] prog_idx,
    output logic [7:0]        prog_byte,
    output logic              erase_fire
);

    localparam int unsigned TMAX = (PGM_CYCLES > ERA_CYCLES) ? PGM_CYCLES : ERA_CYCLES;
    localparam int unsigned TW   = $clog2(TMAX + 1);
    localparam logic [TW-1:0] PGM_LOAD = TW'(PGM_CYCLES - 1);
    localparam logic [TW-1:0] ERA_LOAD = TW'(ERA_CYCLES - 1);

    fsm_t              nxt;
    logic [CMD_AW-1:0] cyc_addr;
    logic [TW-1:0]     tmr;
    logic              id_base;
    fsm_t              rest;
    logic              key_a_hit;
    logic              key_b_hit;
    logic              at_key_a;

    // Address of the current write cycle is latched when it opens
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        cyc_addr <= '0;
        else if (wr_start) cyc_addr <= bus_addr;
    end

    assign at_key_a  = (cyc_addr == KEY_ADDR_A);
    assign key_a_hit = at_key_a && (bus_data == KEY_BYTE_A);
    assign key_b_hit = (cyc_addr == KEY_ADDR_B) && (bus_data == KEY_BYTE_B);
    assign rest      = id_base ? S_IDENT : S_READ;

    always_comb begin
        nxt = state;
        unique case (state)
            S_READ, S_IDENT: begin
                if (wr_end && key_a_hit) nxt = S_UNLK1;
            end
            S_UNLK1: begin
                if (wr_end) nxt = key_b_hit ? S_UNLK2 : rest;
            end
            S_UNLK2: begin
                if (wr_end) begin
                    if (!at_key_a)                    nxt = rest;
                    else if (bus_data == OP_PROGRAM)  nxt = S_PGM_WAIT;
                    else if (bus_data == OP_IDENT)    nxt = S_IDENT;
                    else if (bus_data == OP_RESET)    nxt = S_READ;
                    else if (bus_data == OP_ERASE)    nxt = S_ERA_UNLK0;
                    else                              nxt = rest;
                end
            end
            S_PGM_WAIT: begin
                if (wr_end) nxt = S_PGM_RUN;
            end
            S_PGM_RUN: begin
                if (tmr == '0) nxt = S_READ;
            end
            S_ERA_UNLK0: begin
                if (wr_end) nxt = key_a_hit ? S_ERA_UNLK1 : rest;
            end
            S_ERA_UNLK1: begin
                if (wr_end) nxt = key_b_hit ? S_ERA_CMD : rest;
            end
            S_ERA_CMD: begin
                if (wr_end) nxt = (at_key_a && bus_data == OP_ERA_CONF) ? S_ERA_RUN : rest;
            end
            S_ERA_RUN: begin
                if (tmr == '0) nxt = S_READ;
            end
            default: nxt = S_READ;
        endcase
    end

    // State register with the countdown and the captured program target
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= S_READ;
            tmr       <= '0;
            id_base   <= 1'b0;
            prog_idx  <= '0;
            prog_byte <= 8'hFF;
        end else begin
            state <= nxt;
            if (nxt == S_IDENT)     id_base <= 1'b1;
            else if (nxt == S_READ) id_base <= 1'b0;
            if (state == S_PGM_WAIT && wr_end) begin
                prog_idx  <= cyc_addr[MEM_AW-1:0];
                prog_byte <= bus_data;
                tmr       <= PGM_LOAD;
            end else if (state == S_ERA_CMD && nxt == S_ERA_RUN) begin
                tmr <= ERA_LOAD;
            end else if (tmr != '0) begin
                tmr <= tmr - 1'b1;
            end
        end
    end

    // Outputs decoded from the state
    always_comb begin
        busy       = 1'b0;
        prog_fire  = 1'b0;
        erase_fire = 1'b0;
        id_view    = 1'b0;
        unique case (state)
            S_PGM_RUN: begin
                busy      = 1'b1;
                prog_fire = (tmr == '0);
            end
            S_ERA_RUN: begin
                busy       = 1'b1;
                erase_fire = (tmr == '0);
            end
            S_IDENT: id_view = 1'b1;
            S_READ:  id_view = 1'b0;
            S_UNLK1, S_UNLK2, S_PGM_WAIT,
            S_ERA_UNLK0, S_ERA_UNLK1, S_ERA_CMD: id_view = id_base;
            default: id_view = 1'b0;
        endcase
    end

endmodule

// File: rtl/pfc_array.sv
`timescale 1ns/1ps
module pfc_array #(
    parameter int unsigned MEM_AW = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_fire,
    input  logic [MEM_AW-1:0] prog_idx,
    input  logic [7:0]        prog_byte,
    input  logic              erase_fire,
    input  logic [MEM_AW-1:0] rd_idx,
    output logic [7:0]        rd_byte
);

    localparam int unsigned DEPTH = 1 << MEM_AW;

    logic [7:0] cells [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) cells[k] <= 8'hFF;
        end else if (erase_fire) begin
            for (int k = 0; k < DEPTH; k++) cells[k] <= 8'hFF;
        end else if (prog_fire) begin
            // A program can only pull bits low
            cells[prog_idx] <= cells[prog_idx] & prog_byte;
        end
    end

    assign rd_byte = cells[rd_idx];

endmodule

// File: rtl/pfc_rdmux.sv
`timescale 1ns/1ps
module pfc_rdmux
    import pfc_pkg::*;
#(
    parameter int unsigned SECT_BITS = 3
) (
    input  fsm_t                       state,
    input  logic                       id_view,
    input  logic [7:0]                 id_lo,
    input  logic [SECT_BITS-1:0]       sect,
    input  logic [(1<<SECT_BITS)-1:0]  prot,
    input  logic [7:0]                 arr_byte,
    input  logic                       poll_bit,
    output logic [7:0]                 rd_byte
);

    logic [7:0] id_byte;

    always_comb begin
        if (id_lo == 8'h00)                          id_byte = MAKER_CODE;
        else if (id_lo == 8'h01)                     id_byte = PART_CODE;
        else if (!id_lo[6] && id_lo[1:0] == 2'b10)   id_byte = {7'b0, prot[sect]};
        else                                         id_byte = 8'h00;
    end

    always_comb begin
        if (state == S_PGM_RUN)      rd_byte = {~poll_bit, 7'b0};
        else if (state == S_ERA_RUN) rd_byte = 8'h00;
        else if (id_view)            rd_byte = id_byte;
        else                         rd_byte = arr_byte;
    end

endmodule

// File: rtl/pflash_cmd_ctrl.sv
`timescale 1ns/1ps
module pflash_cmd_ctrl
    import pfc_pkg::*;
#(
    parameter int unsigned ADDR_W      = 19,
    parameter int unsigned MEM_AW      = 6,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned PGM_CYCLES  = 20,
    parameter int unsigned ERA_CYCLES  = 80
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ce_n,
    input  logic        we_n,
    input  logic        oe_n,
    input  logic [18:0] addr,
    input  logic [7:0]  din,
    output logic [7:0]  dout,
    output logic        dout_en,
    input  logic [7:0]  sect_prot,
    output logic        busy
);

    localparam int unsigned SECT_BITS = 3;
    localparam int unsigned SECT_LSB  = ADDR_W - SECT_BITS;

    fsm_t              state;
    logic              wr_start;
    logic              wr_end;
    logic              rd_on;
    logic              id_view;
    logic              prog_fire;
    logic              erase_fire;
    logic [MEM_AW-1:0] prog_idx;
    logic [7:0]        prog_byte;
    logic [7:0]        arr_byte;
    logic [7:0]        rd_byte;

    pfc_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .ce_n     (ce_n),
        .we_n     (we_n),
        .oe_n     (oe_n),
        .wr_start (wr_start),
        .wr_end   (wr_end),
        .rd_on    (rd_on)
    );

    pfc_seq #(
        .MEM_AW     (MEM_AW),
        .PGM_CYCLES (PGM_CYCLES),
        .ERA_CYCLES (ERA_CYCLES)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_start   (wr_start),
        .wr_end     (wr_end),
        .bus_addr   (addr[CMD_AW-1:0]),
        .bus_data   (din),
        .state      (state),
        .busy       (busy),
        .id_view    (id_view),
        .prog_fire  (prog_fire),
        .prog_idx   (prog_idx),
        .prog_byte  (prog_byte),
        .erase_fire (erase_fire)
    );

    pfc_array #(.MEM_AW(MEM_AW)) u_arr (
        .clk        (clk),
        .rst_n      (rst_n),
        .prog_fire  (prog_fire),
        .prog_idx   (prog_idx),
        .prog_byte  (prog_byte),
        .erase_fire (erase_fire),
        .rd_idx     (addr[MEM_AW-1:0]),
        .rd_byte    (arr_byte)
    );

    pfc_rdmux #(.SECT_BITS(SECT_BITS)) u_rd (
        .state    (state),
        .id_view  (id_view),
        .id_lo    (addr[7:0]),
        .sect     (addr[SECT_LSB +: SECT_BITS]),
        .prot     (sect_prot),
        .arr_byte (arr_byte),
        .poll_bit (prog_byte[7]),
        .rd_byte  (rd_byte)
    );

    assign dout_en = rd_on;
    assign dout    = rd_on ? rd_byte : 8'h00;

endmodule

// File: rtl/pfc_chk.sv
`timescale 1ns/1ps
module pfc_chk
    import pfc_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input fsm_t        state,
    input logic        busy,
    input logic        wr_end,
    input logic [18:0] addr,
    input logic [7:0]  dout,
    input logic        dout_en,
    input logic [7:0]  prog_byte
);

    // R3: the data write of a program sequence starts the embedded run
    a_r3_run_after_data: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_PGM_WAIT && wr_end) |=> (state == S_PGM_RUN));

    // R4: polling read shows inverted bit 7
    a_r4_poll_inverted: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_PGM_RUN && dout_en) |-> (dout == {~prog_byte[7], 7'b0}));

    // R6: leaving busy always lands in array read
    a_r6_busy_release: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (state == S_READ));

    // R7: maker code at low byte 00h in identification mode
    a_r7_maker_code: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDENT && dout_en && addr[7:0] == 8'h00) |-> (dout == MAKER_CODE));

    // R11: reads during erase return zero
    a_r11_erase_reads: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_ERA_RUN && dout_en) |-> (dout == 8'h00));

    // R12: the captured program byte holds during the run
    a_r12_target_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_PGM_RUN) |=> $stable(prog_byte));

    // R2: no data without a read enable
    a_r2_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_en |-> (dout == 8'h00));

endmodule

bind pflash_cmd_ctrl pfc_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .state     (state),
    .busy      (busy),
    .wr_end    (wr_end),
    .addr      (addr),
    .dout      (dout),
    .dout_en   (dout_en),
    .prog_byte (prog_byte)
);

// File: tb/tb_pflash_cmd_ctrl.sv
`timescale 1ns/1ps
module tb_pflash_cmd_ctrl;

    localparam int OP_WR = 0;
    localparam int OP_RD = 1;
    localparam int OP_ID = 2;
    localparam int NV    = 43;

    // {op[1:0], req[3:0], addr[18:0], data[7:0]}
    localparam logic [32:0] VEC [NV] = '{
        {2'd1, 4'd1,  19'h00010, 8'hFF},   // R1 erased after reset
        {2'd0, 4'd3,  19'h05555, 8'hAA},   // R3 program 3Ch
        {2'd0, 4'd3,  19'h02AAA, 8'h55},
        {2'd0, 4'd3,  19'h05555, 8'hA0},
        {2'd0, 4'd3,  19'h00010, 8'h3C},
        {2'd2, 4'd6,  19'h00000, 8'h00},
        {2'd1, 4'd6,  19'h00010, 8'h3C},   // R6
        {2'd0, 4'd5,  19'h05555, 8'hAA},   // R5 program F0h over 3Ch
        {2'd0, 4'd5,  19'h02AAA, 8'h55},
        {2'd0, 4'd5,  19'h05555, 8'hA0},
        {2'd0, 4'd5,  19'h00010, 8'hF0},
        {2'd2, 4'd5,  19'h00000, 8'h00},
        {2'd1, 4'd5,  19'h00010, 8'h30},   // R5 AND
        {2'd0, 4'd7,  19'h05555, 8'hAA},   // R7 enter ident
        {2'd0, 4'd7,  19'h02AAA, 8'h55},
        {2'd0, 4'd7,  19'h05555, 8'h90},
        {2'd1, 4'd7,  19'h00000, 8'hAD},   // R7
        {2'd1, 4'd7,  19'h00001, 8'hA4},   // R7
        {2'd1, 4'd8,  19'h30002, 8'h01},   // R8 sector 3 protected
        {2'd1, 4'd8,  19'h10002, 8'h01},   // R8 sector 1 protected
        {2'd1, 4'd8,  19'h20002, 8'h00},   // R8 sector 2 open
        {2'd1, 4'd8,  19'h00010, 8'h00},   // R8 other ident address
        {2'd0, 4'd9,  19'h05555, 8'hAA},   // R9 broken reset sequence
        {2'd0, 4'd9,  19'h02AAA, 8'h66},
        {2'd1, 4'd9,  19'h00000, 8'hAD},   // R9 still ident
        {2'd0, 4'd9,  19'h05555, 8'hAA},   // R9 proper reset
        {2'd0, 4'd9,  19'h02AAA, 8'h55},
        {2'd0, 4'd9,  19'h05555, 8'hF0},
        {2'd1, 4'd9,  19'h00010, 8'h30},   // R9 array again
        {2'd0, 4'd10, 19'h05555, 8'hAA},   // R10 mismatch then stray writes
        {2'd0, 4'd10, 19'h02AAA, 8'h66},
        {2'd0, 4'd10, 19'h05555, 8'hA0},
        {2'd0, 4'd10, 19'h00010, 8'h00},
        {2'd1, 4'd10, 19'h00010, 8'h30},   // R10 unchanged
        {2'd0, 4'd11, 19'h05555, 8'hAA},   // R11 chip erase
        {2'd0, 4'd11, 19'h02AAA, 8'h55},
        {2'd0, 4'd11, 19'h05555, 8'h80},
        {2'd0, 4'd11, 19'h05555, 8'hAA},
        {2'd0, 4'd11, 19'h02AAA, 8'h55},
        {2'd0, 4'd11, 19'h05555, 8'h10},
        {2'd2, 4'd11, 19'h00000, 8'h00},
        {2'd1, 4'd11, 19'h00010, 8'hFF},   // R11 erased
        {2'd1, 4'd11, 19'h00000, 8'hFF}    // R11 erased
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b1;
    logic        we_n = 1'b1;
    logic        oe_n = 1'b1;
    logic [18:0] addr = '0;
    logic [7:0]  din = '0;
    logic [7:0]  dout;
    logic        dout_en;
    logic [7:0]  sect_prot = 8'b0000_1010;
    logic        busy;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    pflash_cmd_ctrl dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .ce_n      (ce_n),
        .we_n      (we_n),
        .oe_n      (oe_n),
        .addr      (addr),
        .din       (din),
        .dout      (dout),
        .dout_en   (dout_en),
        .sect_prot (sect_prot),
        .busy      (busy)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [18:0] a, input logic [7:0] d);
        addr = a;
        din  = d;
        @(negedge clk) ce_n = 1'b0;
        @(negedge clk) we_n = 1'b0;
        repeat (4) @(negedge clk);
        we_n = 1'b1;
        repeat (4) @(negedge clk);
        ce_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic bus_read(input logic [18:0] a, output logic [7:0] d);
        addr = a;
        @(negedge clk);
        ce_n = 1'b0;
        oe_n = 1'b0;
        repeat (4) @(negedge clk);
        d = dout;
        oe_n = 1'b1;
        ce_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic wait_idle();
        for (int k = 0; k < 500; k++) begin
            if (!busy) break;
            @(negedge clk);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        report();
    end

    initial begin
        logic [7:0] rd;
        logic       saw_busy;
        logic       done;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R1 reset state
        check("R1 busy", {7'b0, busy}, 8'h00);
        // R2 idle bus
        check("R2 dout_en idle", {7'b0, dout_en}, 8'h00);
        check("R2 dout idle", dout, 8'h00);
        ce_n = 1'b0;
        repeat (4) @(negedge clk);
        check("R2 ce only", {7'b0, dout_en}, 8'h00);
        ce_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            logic [1:0]  op;
            logic [3:0]  rq;
            logic [18:0] va;
            logic [7:0]  vd;
            {op, rq, va, vd} = VEC[i];
            if (op == OP_WR) bus_write(va, vd);
            else if (op == OP_ID) wait_idle();
            else begin
                bus_read(va, rd);
                check($sformatf("R%0d vector %0d", rq, i), rd, vd);
            end
        end

        // R3/R4/R6: program 5Ah, then poll through the completion cycle
        bus_write(19'h05555, 8'hAA);
        bus_write(19'h02AAA, 8'h55);
        bus_write(19'h05555, 8'hA0);
        bus_write(19'h00020, 8'h5A);
        check("R3 busy after data", {7'b0, busy}, 8'h01);
        addr = 19'h00020;
        ce_n = 1'b0;
        oe_n = 1'b0;
        repeat (3) @(negedge clk);
        saw_busy = 1'b0;
        done = 1'b0;
        for (int k = 0; k < 100; k++) begin
            if (busy) begin
                saw_busy = 1'b1;
                if (dout !== 8'h80) begin
                    n_chk++;
                    n_bad++;
                    $display("FAIL R4 poll: actual %h expected %h", dout, 8'h80);
                end
            end else begin
                check("R6 first byte after busy", dout, 8'h5A);
                done = 1'b1;
                break;
            end
            @(negedge clk);
        end
        check("R4 polled while busy", {7'b0, saw_busy}, 8'h01);
        check("R6 completion seen", {7'b0, done}, 8'h01);
        oe_n = 1'b1;
        ce_n = 1'b1;
        repeat (2) @(negedge clk);

        // R11/R12: writes during erase are ignored
        bus_write(19'h05555, 8'hAA);
        bus_write(19'h02AAA, 8'h55);
        bus_write(19'h05555, 8'h80);
        bus_write(19'h05555, 8'hAA);
        bus_write(19'h02AAA, 8'h55);
        bus_write(19'h05555, 8'h10);
        bus_write(19'h05555, 8'hAA);
        bus_write(19'h02AAA, 8'h55);
        bus_write(19'h05555, 8'h90);
        check("R12 still busy", {7'b0, busy}, 8'h01);
        bus_read(19'h00000, rd);
        check("R12 erase read unchanged", rd, 8'h00);
        wait_idle();
        bus_read(19'h00000, rd);
        check("R11 array after erase", rd, 8'hFF);
        bus_read(19'h00020, rd);
        check("R11 programmed byte erased", rd, 8'hFF);

        report();
    end

endmodule